// File: doc/BRIEF.md
# Two-Backplane Multiplexed LCD Segment Driver

This block generates the drive codes for a liquid-crystal panel that has two backplanes. Each segment line serves two segments: one whose counter-electrode is backplane A and one whose counter-electrode is backplane B. The configured panel holds 3¾ seven-segment digits, three decimal points and eleven annunciators. The annunciators cover polarity, AC, low battery and range units. Every output is a two-bit code for low, middle or high level. A resistor-string stage outside the block turns these codes into voltages, with the middle level at half the peak.

A frame is split into four phases of equal length. During the first two phases backplane A is active: it goes high, then low. Backplane B rests at the middle level. During the last two phases the roles of the two backplanes swap. While a backplane is active, a segment line takes the level opposite to that backplane if its segment is on, and the same level as that backplane if its segment is off. This gives every pixel zero average voltage over a frame. An on pixel sees √5 times the RMS voltage of an off pixel. The segment-on bits are captured only at the frame boundary, so every frame is balanced whatever the latches upstream do.

With a 60 kHz master clock and `PHASE_LEN` = 200, the refresh rate is 75 Hz.

Top module: `duplex_lcd_drv`

## Requirements
- R1: While reset is held, and after it is released but before the first clock edge, the block is in phase 0 with all captured segment bits cleared. Backplane A is high, backplane B is at the middle level, and every segment line is high.
- R2: The level codes are 2'b00 for low, 2'b01 for middle and 2'b10 for high. The code 2'b11 never appears on any output.
- R3: Each phase lasts exactly `PHASE_LEN` clock cycles, and the phases run in the order 0, 1, 2, 3, 0, and so on.
- R4: Backplane A is high, low, middle, middle in phases 0 to 3. Backplane B is middle, middle, high, low. At least one of the two backplanes is always at the middle level.
- R5: In phases 0 and 1, segment line i (bits 2i+1:2i of `seg_drv`) is opposite to backplane A when captured bit `on_a[i]` is 1, and equal to it when that bit is 0. In phases 2 and 3, the same rule applies using backplane B and `on_b[i]`.
- R6: Segment lines are only ever driven low or high, never to the middle level.
- R7: For every pixel, the sum of (backplane level − segment level) over one full frame is zero, with levels counted 0, 1, 2.
- R8: Over one frame, the sum of squared pixel levels is 10·`PHASE_LEN` for an on pixel and 2·`PHASE_LEN` for an off pixel.
- R9: `on_a` and `on_b` are captured only at the clock edge that ends phase 3. Input changes at any other edge have no effect on the outputs before the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| on_a | input | LINES | Segment-on bits for the pixels on backplane A, one per line |
| on_b | input | LINES | Segment-on bits for the pixels on backplane B, one per line |
| bp_a | output | 2 | Level code for backplane A |
| bp_b | output | 2 | Level code for backplane B |
| seg_drv | output | 2·LINES | Level code for each segment line; line i is at bits 2i+1:2i |

## Verification
All outputs are decoded combinationally from the phase counter and the captured bits. After clock edge k (counted from reset release), the phase is (k / `PHASE_LEN`) mod 4. Segment data present at an edge k that is a multiple of 4·`PHASE_LEN` shapes the waveform from that same edge onward. The bench counts edges itself and samples on each falling edge, half a period after the update. It updates its model of the captured bits only at the frame-boundary edges. It closes the per-pixel sum and sum-of-squares checks on the last sample of each frame. It also drives changing junk values on the inputs everywhere except at the capture edge.

// File: rtl/duplex_lcd_drv.sv
module duplex_lcd_drv #(
  parameter int LINES     = 20,
  parameter int PHASE_LEN = 200
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LINES-1:0]   on_a,
  input  logic [LINES-1:0]   on_b,
  output logic [1:0]         bp_a,
  output logic [1:0]         bp_b,
  output logic [2*LINES-1:0] seg_drv
);
  localparam int CW = $clog2(PHASE_LEN + 1);
  localparam logic [1:0] LV_LO  = 2'b00;
  localparam logic [1:0] LV_MID = 2'b01;
  localparam logic [1:0] LV_HI  = 2'b10;

  logic [CW-1:0]    cnt;
  logic [1:0]       phase;
  logic [LINES-1:0] hold_a, hold_b;
  logic             last, wrap, pos, grp_b;

  assign last  = (cnt == CW'(PHASE_LEN - 1));
  assign wrap  = last && (phase == 2'd3);
  assign pos   = ~phase[0];
  assign grp_b = phase[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      phase  <= 2'd0;
      hold_a <= '0;
      hold_b <= '0;
    end else begin
      cnt <= last ? '0 : cnt + CW'(1);
      if (last) phase <= phase + 2'd1;
      if (wrap) begin
        hold_a <= on_a;
        hold_b <= on_b;
      end
    end
  end

  assign bp_a = grp_b ? LV_MID : (pos ? LV_HI : LV_LO);
  assign bp_b = grp_b ? (pos ? LV_HI : LV_LO) : LV_MID;

  for (genvar i = 0; i < LINES; i++) begin : g_line
    logic on_w;
    assign on_w = grp_b ? hold_b[i] : hold_a[i];
    assign seg_drv[2*i +: 2] = (on_w ^ pos) ? LV_HI : LV_LO;
  end

  // R3: phase steps by one only after the last count of a phase
  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> phase == $past(phase) + 2'd1);
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !last |=> $stable(phase));
  // R2, R4: never code 3, one backplane always resting
  a_r2_bp_legal: assert property (@(posedge clk) disable iff (!rst_n)
    bp_a != 2'b11 && bp_b != 2'b11);
  a_r4_one_resting: assert property (@(posedge clk) disable iff (!rst_n)
    bp_a == LV_MID || bp_b == LV_MID);
  // R9: captured bits move only at the frame boundary
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !wrap |=> $stable(hold_a) && $stable(hold_b));

  // R6: segment lines never at middle level
  for (genvar j = 0; j < LINES; j++) begin : g_chk
    a_r6_seg_two_level: assert property (@(posedge clk) disable iff (!rst_n)
      seg_drv[2*j +: 2] == LV_LO || seg_drv[2*j +: 2] == LV_HI);
  end
endmodule

// File: tb/duplex_lcd_drv_test.sv
module duplex_lcd_drv_test;
  localparam int CLK   = 10;
  localparam int LN    = 4;
  localparam int PL    = 3;
  localparam int F     = 4 * PL;
  localparam int TOTAL = 257 * F;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [LN-1:0]   on_a = '0, on_b = '0;
  logic [1:0]      bp_a, bp_b;
  logic [2*LN-1:0] seg_drv;

  int vectors = 0;
  int misses  = 0;

  duplex_lcd_drv #(.LINES(LN), .PHASE_LEN(PL)) uut (
    .clk(clk), .rst_n(rst_n), .on_a(on_a), .on_b(on_b),
    .bp_a(bp_a), .bp_b(bp_b), .seg_drv(seg_drv));

  always #(CLK/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      misses++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #(CLK * 400000);
    misses++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    logic [LN-1:0] ea, eb;
    int acc[2*LN];
    int sq[2*LN];
    ea = '0; eb = '0;
    for (int p = 0; p < 2*LN; p++) begin acc[p] = 0; sq[p] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < TOTAL; k++) begin
      int ph, ebpa, ebpb;
      logic [2*LN-1:0] eseg;
      logic [7:0] nv;
      int kn;
      if (k > 0) begin
        @(posedge clk);
        if (k % F == 0) begin ea = on_a; eb = on_b; end
        @(negedge clk);
      end
      #1;
      ph = (k / PL) % 4;
      if (k == 0) begin
        // R1: reset state
        chk("R1 bp_a", bp_a, 2);
        chk("R1 bp_b", bp_b, 1);
        chk("R1 seg_drv", seg_drv, 8'hAA);
      end
      // R2, R3, R4: backplane sequence with phase length PL
      ebpa = (ph == 0) ? 2 : (ph == 1) ? 0 : 1;
      ebpb = (ph == 2) ? 2 : (ph == 3) ? 0 : 1;
      chk("R4 bp_a", bp_a, ebpa);
      chk("R3 bp_b", bp_b, ebpb);
      // R5, R6, R9: segment line levels from captured bits
      for (int i = 0; i < LN; i++) begin
        logic on;
        int act_bp;
        on = (ph >= 2) ? eb[i] : ea[i];
        act_bp = (ph >= 2) ? ebpb : ebpa;
        eseg[2*i +: 2] = on ? 2'(2 - act_bp) : 2'(act_bp);
      end
      chk("R5 seg_drv", seg_drv, eseg);
      for (int i = 0; i < LN; i++) begin
        int va, vb;
        va = int'(bp_a) - int'(seg_drv[2*i +: 2]);
        vb = int'(bp_b) - int'(seg_drv[2*i +: 2]);
        acc[i] += va; sq[i] += va * va;
        acc[LN+i] += vb; sq[LN+i] += vb * vb;
      end
      if (k % F == F - 1) begin
        for (int i = 0; i < LN; i++) begin
          chk("R7 dc_a", acc[i], 0);
          chk("R7 dc_b", acc[LN+i], 0);
          chk("R8 rms_a", sq[i], ea[i] ? 10 * PL : 2 * PL);
          chk("R8 rms_b", sq[LN+i], eb[i] ? 10 * PL : 2 * PL);
        end
        for (int p = 0; p < 2*LN; p++) begin acc[p] = 0; sq[p] = 0; end
      end
      // R9: junk inputs except at the capture edge
      kn = k + 1;
      if (kn % F == 0) nv = 8'(kn / F - 1);
      else nv = 8'(kn / F) ^ 8'h5A ^ 8'(kn);
      on_a = nv[3:0];
      on_b = nv[7:4];
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule